// File: doc/BRIEF.md
# Majority-Clocked Keystream Generator

This block produces a 228-bit keystream for one radio frame. Three linear feedback shift registers of 19, 22 and 23 bits are cleared and then filled from a 64-bit session key and a 22-bit frame number. They are then stirred for 100 steps with no output. After that they produce one keystream bit per accepted transfer. During the stirring and output phases each register steps only when its clocking bit agrees with the majority of the three clocking bits.

The keystream leaves on a valid/ready stream, one bit per transfer. A transfer takes place on a rising clock edge where both `ks_valid` and `ks_ready` are high. While `ks_ready` is low, the registers hold, and `ks_bit` and `ks_second_half` stay stable. The stream has two halves. Bits 0 to 113 form the first half and serve one direction of transfer. Bits 114 to 227 form the second half and serve the other direction. A plaintext bit presented on `pt_bit` alongside a first-half transfer is XORed with the keystream bit and appears on `ct_bit`.

The control pins are plain levels and pulses. `start` is a one-cycle request. `busy` covers the whole run. `done` rises after the last transfer and stays high until the next accepted start.

Top module: `keystream_gen`

## Requirements
- R1: After reset, `busy`, `done` and `ks_valid` are all low.
- R2: An accepted start captures `key` and `frame_num` and clears all three registers to zero. The next 64 cycles each step all three registers together, taking key bits from bit 0 upward. Each register's new LSB is the XOR of that key bit and its feedback taps: bits 13, 16, 17, 18 of the 19-bit register, bits 20, 21 of the 22-bit register, and bits 7, 20, 21, 22 of the 23-bit register. The other bits move one place toward the MSB, and the old MSB is dropped.
- R3: After the key cycles come 22 cycles that step all three registers in the same way, taking `frame_num` bits from bit 0 upward.
- R4: In the stirring and output phases the clocking bits are bit 8, bit 10 and bit 10 of the three registers. A register steps only when its clocking bit equals the majority of the three, so at least two registers step on every step.
- R5: 100 majority-clocked stirring steps follow loading, with `ks_valid` low throughout. `ks_valid` first goes high 186 clock edges after the edge that accepted the start.
- R6: Keystream bit k is the XOR of the three register MSBs taken before the step that its transfer causes. Exactly 228 bits are offered.
- R7: `ks_second_half` is 0 while bits 0 to 113 are offered and 1 while bits 114 to 227 are offered.
- R8: `ct_bit` equals `ks_bit ^ pt_bit` for first-half bits. For second-half bits `pt_bit` is ignored and `ct_bit` equals `ks_bit`.
- R9: While `ks_valid` is high and `ks_ready` is low, the registers do not step, and the offered bit does not change.
- R10: `busy` is high from the cycle after an accepted start until the last transfer. At that point `done` goes high and stays high until the next accepted start. `busy` and `done` are never high together.
- R11: A start request while `busy` is high is ignored. The run in progress and its keystream are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; accepted only when not busy |
| key | input | 64 | Session key, sampled on the accepted start |
| frame_num | input | 22 | Frame number, sampled on the accepted start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last keystream bit has been transferred |
| ks_valid | output | 1 | A keystream bit is offered |
| ks_ready | input | 1 | Consumer accepts the offered bit |
| ks_bit | output | 1 | Offered keystream bit |
| ks_second_half | output | 1 | Offered bit belongs to the second 114-bit half |
| pt_bit | input | 1 | Plaintext bit paired with the offered bit |
| ct_bit | output | 1 | Ciphertext for first-half bits, keystream bit for second-half bits |

## Verification
Several key and frame patterns are used, and each separates a different class of fault:
- An all-zero key and frame must give an all-zero stream.
- A key with only its lowest bit set exposes the feeding order and the tap positions.
- A frame number with the key cleared isolates frame loading.
- Dense mixed patterns exercise the majority stepping in all of its cases.

The same frames are replayed with a consumer that keeps stalling, to show that back-pressure neither skips nor repeats a bit. Alternating plaintext checks the XOR on the first half and its absence on the second half. A start request inserted mid-run must leave the stream identical to the reference.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_KEY, PH_FRAME, PH_MIX, PH_GEN} phase_t;

  localparam int NUM_REGS = 3;

  function automatic int reg_len(input int i);
    case (i)
      0: return 19;
      1: return 22;
      default: return 23;
    endcase
  endfunction

  function automatic logic [31:0] reg_taps(input int i);
    case (i)
      0: return (32'd1 << 13) | (32'd1 << 16) | (32'd1 << 17) | (32'd1 << 18);
      1: return (32'd1 << 20) | (32'd1 << 21);
      default: return (32'd1 << 7) | (32'd1 << 20) | (32'd1 << 21) | (32'd1 << 22);
    endcase
  endfunction

  function automatic int reg_clk_idx(input int i);
    return (i == 0) ? 8 : 10;
  endfunction
endpackage

// File: rtl/ksg_lfsr.sv
module ksg_lfsr #(
  parameter int          LEN     = 19,
  parameter logic [31:0] TAPS    = 32'h0007_2000,
  parameter int          CLK_IDX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic inj,
  output logic msb,
  output logic cbit
);
  logic [LEN-1:0] sr;
  logic           fb;

  assign fb   = (^(sr & TAPS[LEN-1:0])) ^ inj;
  assign msb  = sr[LEN-1];
  assign cbit = sr[CLK_IDX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (clear) sr <= '0;
    else if (step)  sr <= {sr[LEN-2:0], fb};
  end
endmodule

// File: rtl/ksg_ctrl.sv
module ksg_ctrl
  import ksg_pkg::*;
#(
  parameter int KEY_BITS    = 64,
  parameter int FRAME_BITS  = 22,
  parameter int MIX_CYCLES  = 100,
  parameter int STREAM_BITS = 228,
  parameter int CW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          xfer,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic          accept,
  output logic          busy,
  output logic          done
);
  assign accept = start && (phase == PH_IDLE);
  assign busy   = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (accept) begin
      phase <= PH_KEY;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      case (phase)
        PH_KEY:
          if (cnt == CW'(KEY_BITS - 1)) begin phase <= PH_FRAME; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_FRAME:
          if (cnt == CW'(FRAME_BITS - 1)) begin phase <= PH_MIX; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_MIX:
          if (cnt == CW'(MIX_CYCLES - 1)) begin phase <= PH_GEN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        PH_GEN:
          if (xfer) begin
            if (cnt == CW'(STREAM_BITS - 1)) begin
              phase <= PH_IDLE;
              cnt   <= '0;
              done  <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/keystream_gen.sv
module keystream_gen
  import ksg_pkg::*;
#(
  parameter int KEY_BITS    = 64,
  parameter int FRAME_BITS  = 22,
  parameter int MIX_CYCLES  = 100,
  parameter int STREAM_BITS = 228
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [KEY_BITS-1:0]   key,
  input  logic [FRAME_BITS-1:0] frame_num,
  output logic                  busy,
  output logic                  done,
  output logic                  ks_valid,
  input  logic                  ks_ready,
  output logic                  ks_bit,
  output logic                  ks_second_half,
  input  logic                  pt_bit,
  output logic                  ct_bit
);
  localparam int HALF_BITS = STREAM_BITS / 2;
  localparam int MAX_CNT   = (STREAM_BITS > MIX_CYCLES) ? STREAM_BITS : MIX_CYCLES;
  localparam int CW        = $clog2(MAX_CNT + 1);

  phase_t              phase;
  logic [CW-1:0]       cnt;
  logic                accept, xfer, inj, maj, load_ph, maj_ph;
  logic [KEY_BITS-1:0]   key_sh;
  logic [FRAME_BITS-1:0] frame_sh;
  logic [NUM_REGS-1:0]   msbs, cbits, steps;

  ksg_ctrl #(
    .KEY_BITS(KEY_BITS), .FRAME_BITS(FRAME_BITS),
    .MIX_CYCLES(MIX_CYCLES), .STREAM_BITS(STREAM_BITS), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer(xfer),
    .phase(phase), .cnt(cnt), .accept(accept), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_sh   <= '0;
      frame_sh <= '0;
    end else if (accept) begin
      key_sh   <= key;
      frame_sh <= frame_num;
    end else if (phase == PH_KEY) begin
      key_sh   <= key_sh >> 1;
    end else if (phase == PH_FRAME) begin
      frame_sh <= frame_sh >> 1;
    end
  end

  assign ks_valid = (phase == PH_GEN);
  assign xfer     = ks_valid && ks_ready;
  assign load_ph  = (phase == PH_KEY) || (phase == PH_FRAME);
  assign maj_ph   = (phase == PH_MIX) || xfer;
  assign inj      = (phase == PH_KEY) ? key_sh[0] :
                    (phase == PH_FRAME) ? frame_sh[0] : 1'b0;
  assign maj      = (cbits[0] & cbits[1]) | (cbits[0] & cbits[2]) | (cbits[1] & cbits[2]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign steps[g] = load_ph || (maj_ph && (cbits[g] == maj));
    ksg_lfsr #(
      .LEN(reg_len(g)), .TAPS(reg_taps(g)), .CLK_IDX(reg_clk_idx(g))
    ) u_lfsr (
      .clk(clk), .rst_n(rst_n), .clear(accept), .step(steps[g]),
      .inj(inj), .msb(msbs[g]), .cbit(cbits[g])
    );
  end

  assign ks_bit         = ^msbs;
  assign ks_second_half = ks_valid && (cnt >= CW'(HALF_BITS));
  assign ct_bit         = ks_bit ^ (pt_bit & ~ks_second_half);
endmodule

// File: rtl/keystream_gen_chk.sv
module keystream_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       ks_valid,
  input logic       ks_ready,
  input logic       ks_bit,
  input logic       ks_second_half,
  input logic       pt_bit,
  input logic       ct_bit,
  input logic       maj_ph,
  input logic [2:0] steps
);
  p_valid_needs_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ks_valid);

  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_majority_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    maj_ph |-> ($countones(steps) >= 2));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_ready) |=> (ks_valid && $stable(ks_bit) && $stable(ks_second_half)));

  p_second_half_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && ks_second_half) |-> (ct_bit == ks_bit));

  p_half_no_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && ks_second_half) |=> (!ks_valid || ks_second_half));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(ks_valid && ks_ready)) |=> busy);

  p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind keystream_gen keystream_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ks_valid(ks_valid), .ks_ready(ks_ready), .ks_bit(ks_bit),
  .ks_second_half(ks_second_half), .pt_bit(pt_bit), .ct_bit(ct_bit),
  .maj_ph(maj_ph), .steps(steps)
);

// File: tb/sim_keystream_gen.sv
`timescale 1ns/1ps
module sim_keystream_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] key = '0;
  logic [21:0] frame_num = '0;
  logic        ks_ready = 1'b0;
  logic        pt_bit = 1'b0;
  logic        busy, done, ks_valid, ks_bit, ks_second_half, ct_bit;

  int errors = 0;
  int checks = 0;
  bit exp_ks [228];

  always #2 clk = ~clk;

  keystream_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .frame_num(frame_num),
    .busy(busy), .done(done), .ks_valid(ks_valid), .ks_ready(ks_ready),
    .ks_bit(ks_bit), .ks_second_half(ks_second_half), .pt_bit(pt_bit), .ct_bit(ct_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Behavioural reference: bit-level registers, shifted toward the MSB.
  task automatic ref_model(input logic [63:0] k, input logic [21:0] f);
    logic [18:0] a = '0;
    logic [21:0] b = '0;
    logic [22:0] c = '0;
    logic m, in;
    for (int i = 0; i < 86; i++) begin
      in = (i < 64) ? k[i] : f[i-64];
      a = {a[17:0], a[13]^a[16]^a[17]^a[18]^in};
      b = {b[20:0], b[20]^b[21]^in};
      c = {c[21:0], c[7]^c[20]^c[21]^c[22]^in};
    end
    for (int i = 0; i < 328; i++) begin
      if (i >= 100) exp_ks[i-100] = a[18]^b[21]^c[22];
      m = (a[8]&b[10]) | (a[8]&c[10]) | (b[10]&c[10]);
      if (a[8] == m) a = {a[17:0], a[13]^a[16]^a[17]^a[18]};
      if (b[10] == m) b = {b[20:0], b[20]^b[21]};
      if (c[10] == m) c = {c[21:0], c[7]^c[20]^c[21]^c[22]};
    end
  endtask

  // stall_mode: 0 = always ready, 1 = stall pattern; poke = start request mid-run
  task automatic run_frame(input logic [63:0] k, input logic [21:0] f,
                           input int stall_mode, input bit poke);
    int wait_cyc = 0;
    int idx = 0;
    int cyc = 0;
    ref_model(k, f);
    @(negedge clk);
    key = k; frame_num = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    key = ~k; frame_num = ~f;  // changing inputs after capture must not matter (R2)
    check(busy === 1'b1, "R10 busy after start", busy, 1);
    check(done === 1'b0, "R10 done cleared", done, 0);
    while (!ks_valid && wait_cyc < 400) begin
      if (poke && wait_cyc == 120) start = 1'b1;   // R11: ignored while busy
      if (poke && wait_cyc == 121) start = 1'b0;
      @(negedge clk);
      wait_cyc++;
    end
    start = 1'b0;
    check(wait_cyc == 186, "R5 first valid latency", wait_cyc, 186);
    while (idx < 228 && cyc < 2000) begin
      ks_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      pt_bit   = ((idx + cyc) % 2) == 0;
      if (poke && idx == 50) start = 1'b1;  // R11
      #1;
      check(ks_valid === 1'b1, "R6 valid during stream", ks_valid, 1);
      check(ks_bit === exp_ks[idx], "R6 keystream bit", ks_bit, exp_ks[idx]);
      check(ks_second_half === (idx >= 114), "R7 half flag", ks_second_half, idx >= 114);
      if (idx < 114)
        check(ct_bit === (exp_ks[idx] ^ pt_bit), "R8 first-half cipher", ct_bit, exp_ks[idx] ^ pt_bit);
      else
        check(ct_bit === exp_ks[idx], "R8 second-half plaintext ignored", ct_bit, exp_ks[idx]);
      if (ks_ready) idx++;  // R9: a stall keeps idx, so the same bit must reappear
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    ks_ready = 1'b0;
    #1;
    check(ks_valid === 1'b0, "R6 stream length 228", ks_valid, 0);
    check(busy === 1'b0, "R10 busy low at end", busy, 0);
    check(done === 1'b1, "R10 done after last bit", done, 1);
    @(negedge clk);
    check(done === 1'b1, "R10 done holds", done, 1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy reset", busy, 0);
    check(done === 1'b0, "R1 done reset", done, 0);
    check(ks_valid === 1'b0, "R1 valid reset", ks_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ks_valid === 1'b0, "R1 idle after reset", ks_valid, 0);
    run_frame(64'h0, 22'h0, 0, 1'b0);                          // R2 zero state
    run_frame(64'h1, 22'h0, 0, 1'b0);                          // R2 bit order, taps
    run_frame(64'h0, 22'h2A_5A5, 0, 1'b0);                     // R3 frame path
    run_frame(64'h0123_4567_89AB_CDEF, 22'h13_4567, 0, 1'b0);  // R4 majority
    run_frame(64'hFEDC_BA98_7654_3210, 22'h3F_0F0F, 1, 1'b0);  // R9 back-pressure
    run_frame(64'hA5A5_5A5A_C3C3_3C3C, 22'h0A_BCDE, 1, 1'b1);  // R11 start ignored
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule